// File: doc/BRIEF.md
# Clock and Battery RAM Command Interpreter

This block is the device-side engine of a real-time clock with battery-backed RAM. A host feeds it a stream of byte transfers, each marked as a write (host to device) or a read (device to host). The engine reads each transaction as a command byte whose top bit selects the direction. The command is followed by a data byte. For the two-byte address form, a second address byte comes between the command and the data. On a read the data byte is the device's answer: the addressed byte appears on `xfer_rdata` one cycle after the read transfer is accepted and stays there until the next read completes.

Internally the block holds a 32-bit seconds counter, a 256-byte RAM, a test register and a write-protect register. The seconds counter counts seconds from midnight, 1 January 1904. It advances on an external one-second tick unless the test control bits are set. The command encoding is irregular. It has four seconds-byte selects, two short RAM windows kept for compatibility (locations 0..15 and 16..19), a two-byte extended address form that reaches all 256 locations, and two write-only register selects. A sticky protect bit blocks every write except a write to the protect register itself.

Top module: `rtc_bram_engine`

## Requirements
- R1: After reset the seconds counter reads 0, protection is off, the test control bits are 0, `xfer_rdata` is 0 and the engine expects a command byte.
- R2: Command `z000ss01` (bits 3:2 = ss) addresses seconds byte ss, with ss=0 the least significant byte. z = bit 7, where 1 means read and 0 means write. A write replaces only that byte, and the new value is visible in the counter from the next cycle.
- R3: Each cycle with `sec_tick` high and both test control bits 0 adds 1 to the counter, wrapping from 0xFFFFFFFF to 0. If a seconds-byte write lands in the same cycle, the write wins and that tick is lost.
- R4: Writing the test register (command 0x31, then data) stores data bits 7:6 as test control. While either bit is 1, `sec_tick` has no effect on the counter.
- R5: Command `z010ab01` addresses RAM location 16 + ab (bits 3:2).
- R6: Command `z1abcd01` addresses RAM location abcd (bits 5:2), in the range 0..15.
- R7: Command `z0111abc` must be followed by a write transfer carrying `0defgh00`. The pair addresses RAM location abcdefgh, and the data transfer comes next. A second byte with bit 7 set, with a nonzero bit 1:0, or sent as a read abandons the transaction.
- R8: Writing the protect register (command 0x35, then data) stores data bit 7. While that bit is 1, writes to the seconds bytes, the test register and RAM have no effect. The protect register itself stays writable.
- R9: A command byte that matches no pattern is discarded, and so is a read-direction access to the test or protect register (0xB1, 0xB5). A read transfer received while a command is expected is ignored. In each of these cases the engine waits for a new command byte.
- R10: On a read, the transfer that follows the command phase loads the addressed byte into `xfer_rdata` one cycle after it is accepted. `xfer_rdata` changes on no other occasion.
- R11: In the data phase, a transfer whose direction differs from the command's direction ends the transaction. It writes nothing and changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse each second |
| xfer_stb | input | 1 | A byte transfer occurs this cycle |
| xfer_rd | input | 1 | Transfer direction: 1 = device to host, 0 = host to device |
| xfer_wdata | input | 8 | Byte from the host |
| xfer_rdata | output | 8 | Last byte returned by a read |

## Verification
The bench fills the RAM using the extended form, then mixes random accesses through all three address forms, seconds-byte writes and ticks. Any mistake in splitting address bits across the two-byte form, or an off-by-16 in the short high window, shows up as a wrong readback from some location. Directed cases cover:
- the 32-bit wrap, which a design carrying only within a byte would get wrong;
- a tick landing on a byte write, where the write must win;
- test mode freezing the counter;
- protection, where a leak would change RAM, seconds or the test bits, and an over-broad block would stop the unprotect write;
- invalid commands, bad second bytes and direction mismatches, where a design that failed to resynchronise would treat the next byte as data.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int BYTE_W     = 8;
  localparam int RAM_AW     = 8;
  localparam int SEC_BYTES  = 4;
  localparam int SEC_SEL_W  = $clog2(SEC_BYTES);
  localparam int SEC_W      = SEC_BYTES * BYTE_W;

  typedef enum logic [2:0] {
    TGT_NONE = 3'd0,
    TGT_SEC  = 3'd1,
    TGT_TEST = 3'd2,
    TGT_WP   = 3'd3,
    TGT_RAM  = 3'd4,
    TGT_EXT  = 3'd5
  } tgt_e;

  typedef enum logic [1:0] {
    ST_CMD  = 2'd0,
    ST_EXT  = 2'd1,
    ST_DATA = 2'd2
  } phase_e;

  typedef struct packed {
    logic                 valid;
    logic                 rd;
    tgt_e                 tgt;
    logic [SEC_SEL_W-1:0] sec_sel;
    logic [RAM_AW-1:0]    addr;
  } cmd_t;
endpackage

// File: rtl/rtc_cmd_decode.sv
module rtc_cmd_decode
  import rtc_pkg::*;
(
  input  logic [BYTE_W-1:0] cmd_byte,
  output cmd_t              cmd
);
  always_comb begin
    cmd         = '0;
    cmd.tgt     = TGT_NONE;
    cmd.rd      = cmd_byte[7];
    if (cmd_byte[6]) begin
      // short low window: locations 0..15
      if (cmd_byte[1:0] == 2'b01) begin
        cmd.tgt  = TGT_RAM;
        cmd.addr = {4'b0000, cmd_byte[5:2]};
      end
    end else begin
      unique case (cmd_byte[5:4])
        2'b00: begin
          if (cmd_byte[1:0] == 2'b01) begin
            cmd.tgt     = TGT_SEC;
            cmd.sec_sel = cmd_byte[3:2];
          end
        end
        2'b10: begin
          // short high window: locations 16..19
          if (cmd_byte[1:0] == 2'b01) begin
            cmd.tgt  = TGT_RAM;
            cmd.addr = {3'b000, 3'b100, cmd_byte[3:2]};
          end
        end
        2'b11: begin
          if (cmd_byte[3]) begin
            cmd.tgt  = TGT_EXT;
            cmd.addr = {cmd_byte[2:0], 5'b00000};
          end else if (!cmd_byte[7] && cmd_byte[3:0] == 4'b0001) begin
            cmd.tgt = TGT_TEST;
          end else if (!cmd_byte[7] && cmd_byte[3:0] == 4'b0101) begin
            cmd.tgt = TGT_WP;
          end
        end
        default: cmd.tgt = TGT_NONE;
      endcase
    end
    cmd.valid = (cmd.tgt != TGT_NONE);
  end
endmodule

// File: rtl/rtc_seconds.sv
module rtc_seconds
  import rtc_pkg::*;
#(
  parameter int NBYTES = SEC_BYTES,
  localparam int SW    = (NBYTES > 1) ? $clog2(NBYTES) : 1,
  localparam int CW    = NBYTES * BYTE_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              hold,
  input  logic              wr_en,
  input  logic [SW-1:0]     wr_sel,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic [CW-1:0]     count
);
  logic [CW-1:0] count_q;
  logic [CW-1:0] count_d;
  logic [CW-1:0] count_inc;
  logic          advance;
  logic          cnt_en;

  assign advance   = tick && !hold;
  assign count_inc = count_q + CW'(1);
  assign cnt_en    = wr_en || advance;

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    always_comb begin
      if (wr_en) begin
        count_d[i*BYTE_W +: BYTE_W] = (wr_sel == SW'(i)) ? wr_byte
                                                         : count_q[i*BYTE_W +: BYTE_W];
      end else begin
        count_d[i*BYTE_W +: BYTE_W] = count_inc[i*BYTE_W +: BYTE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (cnt_en) begin
      count_q <= count_d;
    end
  end

  assign count = count_q;

  AST_SEC_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en) && !$past(tick && !hold)) |-> $stable(count_q)); // R4
  AST_SEC_TICK_INC: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tick && !hold && !wr_en) |-> (count_q == $past(count_q) + CW'(1))); // R3
endmodule

// File: rtl/rtc_bram.sv
module rtc_bram
  import rtc_pkg::*;
#(
  parameter int AW    = RAM_AW,
  localparam int DEPTH = 1 << AW
)(
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata
);
  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/rtc_bram_engine.sv
module rtc_bram_engine
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              xfer_stb,
  input  logic              xfer_rd,
  input  logic [BYTE_W-1:0] xfer_wdata,
  output logic [BYTE_W-1:0] xfer_rdata
);
  cmd_t                 dec;
  phase_e               st_q,   st_d;
  tgt_e                 tgt_q,  tgt_d;
  logic [SEC_SEL_W-1:0] sel_q,  sel_d;
  logic [RAM_AW-1:0]    addr_q, addr_d;
  logic                 rd_q,   rd_d;
  logic                 wp_q,   wp_d;
  logic [1:0]           test_q, test_d;
  logic [BYTE_W-1:0]    rdat_q, rdat_d;
  logic                 sec_we, ram_we;
  logic [BYTE_W-1:0]    ram_rdata;
  logic [SEC_W-1:0]     seconds;
  logic                 ext_ok;
  logic                 rd_done;
  logic                 data_wr;

  rtc_cmd_decode u_dec (
    .cmd_byte (xfer_wdata),
    .cmd      (dec)
  );

  rtc_seconds #(.NBYTES(SEC_BYTES)) u_sec (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (sec_tick),
    .hold    (|test_q),
    .wr_en   (sec_we),
    .wr_sel  (sel_q),
    .wr_byte (xfer_wdata),
    .count   (seconds)
  );

  rtc_bram #(.AW(RAM_AW)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .addr  (addr_q),
    .wdata (xfer_wdata),
    .rdata (ram_rdata)
  );

  assign ext_ok  = !xfer_rd && !xfer_wdata[7] && (xfer_wdata[1:0] == 2'b00);
  assign rd_done = xfer_stb && (st_q == ST_DATA) && rd_q && xfer_rd;
  assign data_wr = xfer_stb && (st_q == ST_DATA) && !rd_q && !xfer_rd;

  // next-state logic
  always_comb begin
    st_d   = st_q;
    tgt_d  = tgt_q;
    sel_d  = sel_q;
    addr_d = addr_q;
    rd_d   = rd_q;
    wp_d   = wp_q;
    test_d = test_q;
    rdat_d = rdat_q;
    sec_we = 1'b0;
    ram_we = 1'b0;
    unique case (st_q)
      ST_CMD: begin
        if (xfer_stb && !xfer_rd && dec.valid) begin
          tgt_d  = dec.tgt;
          sel_d  = dec.sec_sel;
          addr_d = dec.addr;
          rd_d   = dec.rd;
          st_d   = (dec.tgt == TGT_EXT) ? ST_EXT : ST_DATA;
        end
      end
      ST_EXT: begin
        if (xfer_stb) begin
          if (ext_ok) begin
            addr_d = {addr_q[7:5], xfer_wdata[6:2]};
            tgt_d  = TGT_RAM;
            st_d   = ST_DATA;
          end else begin
            st_d = ST_CMD;
          end
        end
      end
      ST_DATA: begin
        if (xfer_stb) begin
          st_d = ST_CMD;
          if (rd_done) begin
            rdat_d = (tgt_q == TGT_SEC) ? seconds[sel_q*BYTE_W +: BYTE_W] : ram_rdata;
          end else if (data_wr) begin
            if (tgt_q == TGT_WP) begin
              wp_d = xfer_wdata[7];
            end else if (!wp_q) begin
              unique case (tgt_q)
                TGT_SEC:  sec_we = 1'b1;
                TGT_TEST: test_d = xfer_wdata[7:6];
                TGT_RAM:  ram_we = 1'b1;
                default:  ;
              endcase
            end
          end
        end
      end
      default: st_d = ST_CMD;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_CMD;
      tgt_q  <= TGT_NONE;
      sel_q  <= '0;
      addr_q <= '0;
      rd_q   <= 1'b0;
      wp_q   <= 1'b0;
      test_q <= 2'b00;
      rdat_q <= '0;
    end else if (xfer_stb) begin
      st_q   <= st_d;
      tgt_q  <= tgt_d;
      sel_q  <= sel_d;
      addr_q <= addr_d;
      rd_q   <= rd_d;
      wp_q   <= wp_d;
      test_q <= test_d;
      rdat_q <= rdat_d;
    end
  end

  assign xfer_rdata = rdat_q;

  AST_IDLE_READ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CMD && xfer_stb && xfer_rd) |=> (st_q == ST_CMD)); // R9
  AST_DATA_ENDS_TXN: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DATA && xfer_stb) |=> (st_q == ST_CMD)); // R11
  AST_EXT_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_EXT) |-> ($past(st_q) == ST_CMD || $past(st_q) == ST_EXT)); // R7
  AST_PROTECT_TEST: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wp_q) |-> $stable(test_q)); // R8
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_done) |-> $stable(rdat_q)); // R10
endmodule

// File: tb/tb_rtc_bram_engine.sv
module tb_rtc_bram_engine;
  logic       clk;
  logic       rst_n;
  logic       sec_tick;
  logic       xfer_stb;
  logic       xfer_rd;
  logic [7:0] xfer_wdata;
  logic [7:0] xfer_rdata;

  int checks = 0;
  int fails  = 0;

  logic [31:0] m_sec;
  logic [7:0]  m_ram [256];
  bit          m_hold;

  rtc_bram_engine dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .sec_tick   (sec_tick),
    .xfer_stb   (xfer_stb),
    .xfer_rd    (xfer_rd),
    .xfer_wdata (xfer_wdata),
    .xfer_rdata (xfer_rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] f_sec(input bit rd, input int k);
    logic [1:0] s = k[1:0];
    return {rd, 3'b000, s, 2'b01};
  endfunction

  task automatic xfer(input bit dir, input logic [7:0] b, output logic [7:0] r);
    @(negedge clk);
    xfer_stb = 1'b1; xfer_rd = dir; xfer_wdata = b;
    @(negedge clk);
    xfer_stb = 1'b0; xfer_rd = 1'b0; xfer_wdata = 8'h00;
    r = xfer_rdata;
  endtask

  task automatic wr(input logic [7:0] b);
    logic [7:0] r;
    xfer(1'b0, b, r);
  endtask

  task automatic rd(output logic [7:0] r);
    xfer(1'b1, 8'h00, r);
  endtask

  // form: 0 extended, 1 short low (0..15), 2 short high (16..19)
  task automatic ram_cmd(input bit dir, input logic [7:0] a, input int form);
    if (form == 1)      wr({dir, 1'b1, a[3:0], 2'b01});
    else if (form == 2) wr({dir, 3'b010, a[1:0], 2'b01});
    else begin
      wr({dir, 4'b0111, a[7:5]});
      wr({1'b0, a[4:0], 2'b00});
    end
  endtask

  task automatic ram_wr(input logic [7:0] a, input logic [7:0] d, input int form);
    ram_cmd(1'b0, a, form);
    wr(d);
  endtask

  task automatic ram_rd(input logic [7:0] a, input int form, output logic [7:0] d);
    ram_cmd(1'b1, a, form);
    rd(d);
  endtask

  task automatic sec_rd(output logic [31:0] v);
    logic [7:0] b;
    for (int k = 0; k < 4; k++) begin
      wr(f_sec(1'b1, k));
      rd(b);
      v[k*8 +: 8] = b;
    end
  endtask

  task automatic tick();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
    if (!m_hold) m_sec = m_sec + 32'd1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0]  d;
    logic [31:0] v;
    int          seed;
    seed = $urandom(1904);
    rst_n = 1'b0; sec_tick = 1'b0; xfer_stb = 1'b0; xfer_rd = 1'b0; xfer_wdata = 8'h00;
    m_sec = 32'd0; m_hold = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 rdata after reset", {24'd0, xfer_rdata}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    sec_rd(v);
    check("R1 seconds after reset", v, 32'h0);
    tick();
    sec_rd(v);
    check("R1 test bits clear, counting", v, m_sec);

    // fill RAM through extended form
    for (int a = 0; a < 256; a++) begin
      m_ram[a] = 8'(a * 37 + 5);
      ram_wr(8'(a), m_ram[a], 0);
    end
    ram_rd(8'hA7, 0, d);
    check("R7 extended readback", {24'd0, d}, {24'd0, m_ram[8'hA7]});
    ram_rd(8'd18, 2, d);
    check("R5 short high window", {24'd0, d}, {24'd0, m_ram[18]});
    ram_rd(8'd9, 1, d);
    check("R6 short low window", {24'd0, d}, {24'd0, m_ram[9]});
    ram_wr(8'd19, 8'h5C, 2); m_ram[19] = 8'h5C;
    ram_rd(8'd19, 0, d);
    check("R5 write via high window", {24'd0, d}, 32'h5C);
    ram_wr(8'd15, 8'hE1, 1); m_ram[15] = 8'hE1;
    ram_rd(8'd15, 0, d);
    check("R6 write via low window", {24'd0, d}, 32'hE1);

    // seconds byte writes
    wr(f_sec(1'b0, 2)); wr(8'h7D); m_sec[23:16] = 8'h7D;
    sec_rd(v);
    check("R2 seconds byte 2 write", v, m_sec);
    // wrap
    for (int k = 0; k < 4; k++) begin wr(f_sec(1'b0, k)); wr(8'hFF); end
    m_sec = 32'hFFFF_FFFF;
    tick();
    sec_rd(v);
    check("R3 32-bit wrap", v, 32'h0);
    // write and tick in same cycle
    wr(f_sec(1'b0, 0));
    @(negedge clk);
    xfer_stb = 1'b1; xfer_rd = 1'b0; xfer_wdata = 8'h42; sec_tick = 1'b1;
    @(negedge clk);
    xfer_stb = 1'b0; xfer_wdata = 8'h00; sec_tick = 1'b0;
    m_sec[7:0] = 8'h42;
    sec_rd(v);
    check("R3 write wins over tick", v, m_sec);

    // test mode
    wr(8'h31); wr(8'h40); m_hold = 1'b1;
    tick(); tick();
    sec_rd(v);
    check("R4 tick ignored in test mode", v, m_sec);
    wr(8'h31); wr(8'h3F); m_hold = 1'b0;
    tick();
    sec_rd(v);
    check("R4 counting resumes", v, m_sec);

    // protection
    wr(8'h35); wr(8'h80);
    ram_wr(8'd33, 8'h00, 0);
    ram_wr(8'd3, 8'h00, 1);
    wr(f_sec(1'b0, 1)); wr(8'hAA);
    wr(8'h31); wr(8'hC0);
    ram_rd(8'd33, 0, d);
    check("R8 RAM write blocked (ext)", {24'd0, d}, {24'd0, m_ram[33]});
    ram_rd(8'd3, 1, d);
    check("R8 RAM write blocked (short)", {24'd0, d}, {24'd0, m_ram[3]});
    tick();
    sec_rd(v);
    check("R8 seconds and test writes blocked", v, m_sec);
    wr(8'h35); wr(8'h00);
    ram_wr(8'd33, 8'h99, 0); m_ram[33] = 8'h99;
    ram_rd(8'd33, 0, d);
    check("R8 unprotect restores writes", {24'd0, d}, 32'h99);

    // invalid commands
    wr(8'h02);
    ram_wr(8'd40, 8'h11, 0); m_ram[40] = 8'h11;
    ram_rd(8'd40, 0, d);
    check("R9 invalid command discarded", {24'd0, d}, 32'h11);
    wr(8'hB1);
    ram_rd(8'd41, 0, d);
    check("R9 read of test reg discarded", {24'd0, d}, {24'd0, m_ram[41]});
    rd(d);
    check("R10 idle read leaves rdata", {24'd0, d}, {24'd0, m_ram[41]});
    // bad second byte
    wr({1'b0, 4'b0111, 3'b001}); wr(8'h81);
    ram_wr(8'd42, 8'h22, 1); m_ram[42 & 15] = 8'h22;
    ram_rd(8'd10, 1, d);
    check("R7 bad second byte abandons", {24'd0, d}, 32'h22);
    // direction mismatch
    ram_cmd(1'b0, 8'd50, 0);
    rd(d);
    check("R11 mismatch keeps rdata", {24'd0, d}, 32'h22);
    ram_rd(8'd50, 0, d);
    check("R11 mismatch writes nothing", {24'd0, d}, {24'd0, m_ram[50]});

    // random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      int form;
      logic [7:0] a;
      logic [7:0] b;
      op = int'($urandom_range(4));
      form = int'($urandom_range(2));
      a = 8'($urandom);
      if (form == 1) a = {4'h0, a[3:0]};
      if (form == 2) a = {6'b000100, a[1:0]};
      b = 8'($urandom);
      case (op)
        0: begin ram_wr(a, b, form); m_ram[a] = b; end
        1: begin ram_rd(a, form, d);
                 check("R5 R6 R7 random RAM read", {24'd0, d}, {24'd0, m_ram[a]}); end
        2: begin wr(f_sec(1'b0, int'(a[1:0]))); wr(b); m_sec[a[1:0]*8 +: 8] = b; end
        3: tick();
        default: begin sec_rd(v); check("R2 R3 random seconds read", v, m_sec); end
      endcase
    end
    sec_rd(v);
    check("R2 final seconds", v, m_sec);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule